// File: doc/BRIEF.md
# Shift-Register FIFO with Write Priority

This block is a small first-in first-out buffer in which the stored words move down a chain of registers. Slot zero always holds the oldest word and drives the data output with no read-side multiplexer. A write places the incoming word in the slot just above the current occupancy. A read moves every slot down by one place. When a write and a read arrive in the same cycle, the read is dropped and only the write is carried out, so a push and a pop never happen together.

A small fill-state machine tracks the occupancy. Its states are `FILL_EMPTY`, `FILL_PARTIAL` and `FILL_FULL`. On each active edge the control logic picks one operation: `OP_PUSH`, `OP_POP`, `OP_HOLD` or `OP_CLEAR`. The named transitions are:
- empty to partial on a push, or empty to full on a push when the depth is one.
- partial to full on a push that fills the last slot.
- partial to empty on a pop of the last word.
- full to partial on a pop, or full to empty on a pop when the depth is one.
- any state to empty on a clear.

Parameters set the depth, the word width and the almost-empty and almost-full levels. Further parameters choose the active clock edge, whether the control inputs are active-low, and whether reset is asynchronous or synchronous. Reset clears only the occupancy. The contents of the data slots are left as they are.

Top module: `sr_fifo`

## Requirements
- R1: On an enabled active edge, with write asserted and occupancy below DEPTH, the occupancy rises by one and `din` is stored behind the words already held.
- R2: On an enabled active edge, with write deasserted, read asserted and occupancy nonzero, the occupancy falls by one and every word moves one place toward the output.
- R3: When write and read are both asserted, only the write is performed. The occupancy rises by one, or stays the same if the buffer is full.
- R4: A write while full, or a read while empty, leaves the occupancy and the output order unchanged.
- R5: `dout` always shows the oldest stored word. A word written into an empty buffer appears on `dout` right after that edge.
- R6: `empty` is high exactly when the occupancy is 0. `full` is high exactly when the occupancy equals DEPTH.
- R7: `almost_empty` is high when the occupancy is at most AE_LEVEL. `almost_full` is high when the occupancy is at least AF_LEVEL.
- R8: While clock enable is deasserted, neither the occupancy nor the stored words change.
- R9: With ASYNC_RESET=1, asserting reset clears the occupancy at once, whatever the state of the clock and the clock enable.
- R10: With ASYNC_RESET=0, reset clears the occupancy only on an active edge on which clock enable is asserted.
- R11: With FALLING_EDGE=1, the block updates on falling clock edges instead of rising ones.
- R12: With ACTIVE_LOW=1, the reset, clock enable, write and read inputs are all asserted at logic 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the active edge is chosen by FALLING_EDGE |
| rst | input | 1 | Reset of the occupancy; polarity set by ACTIVE_LOW |
| clk_en | input | 1 | Clock enable; polarity set by ACTIVE_LOW |
| wr_en | input | 1 | Write request; polarity set by ACTIVE_LOW |
| rd_en | input | 1 | Read request; polarity set by ACTIVE_LOW |
| din | input | WIDTH | Word to store |
| dout | output | WIDTH | Oldest stored word (slot zero) |
| empty | output | 1 | Occupancy is zero |
| full | output | 1 | Occupancy equals DEPTH |
| almost_empty | output | 1 | Occupancy is at most AE_LEVEL |
| almost_full | output | 1 | Occupancy is at least AF_LEVEL |

## Verification
The assertions are evaluated on the internal active edge, after the control inputs have been converted to active-high. They assume that reset is held across the first active edges, so that the occupancy is defined before any past value is compared. They also assume that data and control inputs are steady at the active edge. The bench meets both assumptions. It keeps reset and clock enable asserted for the opening cycles. It changes every input just after the rising edge, so the input is settled half a period before the falling-edge instance samples it and a full period before the rising-edge instance does.

// File: rtl/sr_fifo_pkg.sv
package sr_fifo_pkg;

    typedef enum logic [1:0] {
        FILL_EMPTY   = 2'd0,
        FILL_PARTIAL = 2'd1,
        FILL_FULL    = 2'd2
    } fill_t;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_PUSH  = 2'd1,
        OP_POP   = 2'd2,
        OP_CLEAR = 2'd3
    } op_t;

endpackage

// File: rtl/sr_fifo_ctrl.sv
module sr_fifo_ctrl
    import sr_fifo_pkg::*;
#(
    parameter int DEPTH       = 8,
    parameter int CW          = 4,
    parameter bit ASYNC_RESET = 1'b1
) (
    input  logic          tick,
    input  logic          rst_act,
    input  logic          ce_act,
    input  logic          we_act,
    input  logic          re_act,
    output op_t           op,
    output logic [CW-1:0] count,
    output fill_t         fill
);

    localparam logic [CW-1:0] ONE   = CW'(1);
    localparam logic [CW-1:0] TOPM1 = CW'(DEPTH - 1);
    localparam bit            SINGLE = (DEPTH == 1);

    logic [CW-1:0] count_q, count_nx;
    fill_t         fill_q, fill_nx;

    // operation select: write wins over read
    always_comb begin
        if (rst_act) begin
            op = (!ASYNC_RESET && ce_act) ? OP_CLEAR : OP_HOLD;
        end else if (!ce_act) begin
            op = OP_HOLD;
        end else if (we_act) begin
            op = (fill_q == FILL_FULL) ? OP_HOLD : OP_PUSH;
        end else if (re_act) begin
            op = (fill_q == FILL_EMPTY) ? OP_HOLD : OP_POP;
        end else begin
            op = OP_HOLD;
        end
    end

    // next occupancy
    always_comb begin
        unique case (op)
            OP_PUSH:  count_nx = count_q + ONE;
            OP_POP:   count_nx = count_q - ONE;
            OP_CLEAR: count_nx = '0;
            default:  count_nx = count_q;
        endcase
    end

    // fill-state transitions
    always_comb begin
        fill_nx = fill_q;
        if (op == OP_CLEAR) begin
            fill_nx = FILL_EMPTY;
        end else begin
            unique case (fill_q)
                FILL_EMPTY: begin
                    if (op == OP_PUSH) fill_nx = SINGLE ? FILL_FULL : FILL_PARTIAL;
                end
                FILL_PARTIAL: begin
                    if (op == OP_PUSH && count_q == TOPM1) fill_nx = FILL_FULL;
                    else if (op == OP_POP && count_q == ONE) fill_nx = FILL_EMPTY;
                end
                FILL_FULL: begin
                    if (op == OP_POP) fill_nx = SINGLE ? FILL_EMPTY : FILL_PARTIAL;
                end
                default: fill_nx = FILL_EMPTY;
            endcase
        end
    end

    generate
        if (ASYNC_RESET) begin : g_async
            always_ff @(posedge tick or posedge rst_act) begin
                if (rst_act) begin
                    count_q <= '0;
                    fill_q  <= FILL_EMPTY;
                end else begin
                    count_q <= count_nx;
                    fill_q  <= fill_nx;
                end
            end
        end else begin : g_sync
            always_ff @(posedge tick) begin
                count_q <= count_nx;
                fill_q  <= fill_nx;
            end
        end
    endgenerate

    assign count = count_q;
    assign fill  = fill_q;

endmodule

// File: rtl/sr_fifo_store.sv
module sr_fifo_store
    import sr_fifo_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int WIDTH = 8,
    parameter int CW    = 4
) (
    input  logic             tick,
    input  op_t              op,
    input  logic [CW-1:0]    count,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    // DEPTH+1 slots; the top one is a spare that never receives a word
    logic [WIDTH-1:0] slot [DEPTH+1];

    generate
        for (genvar i = 0; i <= DEPTH; i++) begin : g_slot
            if (i < DEPTH) begin : g_shift
                always_ff @(posedge tick) begin
                    if (op == OP_PUSH && count == CW'(i)) slot[i] <= din;
                    else if (op == OP_POP) slot[i] <= slot[i+1];
                end
            end else begin : g_spare
                always_ff @(posedge tick) begin
                    if (op == OP_PUSH && count == CW'(i)) slot[i] <= din;
                end
            end
        end
    endgenerate

    assign dout = slot[0];

endmodule

// File: rtl/sr_fifo_flags.sv
module sr_fifo_flags
    import sr_fifo_pkg::*;
#(
    parameter int CW       = 4,
    parameter int AE_LEVEL = 2,
    parameter int AF_LEVEL = 6
) (
    input  logic [CW-1:0] count,
    input  fill_t         fill,
    output logic          empty,
    output logic          full,
    output logic          almost_empty,
    output logic          almost_full
);

    localparam logic [CW-1:0] AE_C = CW'(AE_LEVEL);
    localparam logic [CW-1:0] AF_C = CW'(AF_LEVEL);

    always_comb begin
        empty        = (fill == FILL_EMPTY);
        full         = (fill == FILL_FULL);
        almost_empty = (count <= AE_C);
        almost_full  = (count >= AF_C);
    end

endmodule

// File: rtl/sr_fifo.sv
module sr_fifo
    import sr_fifo_pkg::*;
#(
    parameter int DEPTH        = 8,
    parameter int WIDTH        = 8,
    parameter int AE_LEVEL     = 2,
    parameter int AF_LEVEL     = 6,
    parameter bit FALLING_EDGE = 1'b0,
    parameter bit ACTIVE_LOW   = 1'b0,
    parameter bit ASYNC_RESET  = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clk_en,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full,
    output logic             almost_empty,
    output logic             almost_full
);

    localparam int CW = $clog2(DEPTH + 1);

    logic          tick, rst_act, ce_act, we_act, re_act;
    op_t           op;
    logic [CW-1:0] count;
    fill_t         fill;

    assign tick    = clk    ^ FALLING_EDGE;
    assign rst_act = rst    ^ ACTIVE_LOW;
    assign ce_act  = clk_en ^ ACTIVE_LOW;
    assign we_act  = wr_en  ^ ACTIVE_LOW;
    assign re_act  = rd_en  ^ ACTIVE_LOW;

    sr_fifo_ctrl #(.DEPTH(DEPTH), .CW(CW), .ASYNC_RESET(ASYNC_RESET)) u_ctrl (
        .tick(tick), .rst_act(rst_act), .ce_act(ce_act),
        .we_act(we_act), .re_act(re_act),
        .op(op), .count(count), .fill(fill)
    );

    sr_fifo_store #(.DEPTH(DEPTH), .WIDTH(WIDTH), .CW(CW)) u_store (
        .tick(tick), .op(op), .count(count), .din(din), .dout(dout)
    );

    sr_fifo_flags #(.CW(CW), .AE_LEVEL(AE_LEVEL), .AF_LEVEL(AF_LEVEL)) u_flags (
        .count(count), .fill(fill),
        .empty(empty), .full(full),
        .almost_empty(almost_empty), .almost_full(almost_full)
    );

endmodule

// File: rtl/sr_fifo_chk.sv
module sr_fifo_chk #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 8,
    parameter int CW    = 4
) (
    input logic             tick,
    input logic             rst_act,
    input logic             ce_act,
    input logic             we_act,
    input logic             re_act,
    input logic [CW-1:0]    count,
    input logic [WIDTH-1:0] din,
    input logic [WIDTH-1:0] dout,
    input logic             empty,
    input logic             full
);

    a_r1_push_inc: assert property (@(posedge tick) disable iff (rst_act)
        (ce_act && we_act && !full) |=> count == CW'($past(count) + 1'b1));

    a_r2_pop_dec: assert property (@(posedge tick) disable iff (rst_act)
        (ce_act && !we_act && re_act && !empty) |=> count == CW'($past(count) - 1'b1));

    a_r3_write_wins: assert property (@(posedge tick) disable iff (rst_act)
        (ce_act && we_act && re_act && full) |=> $stable(count));

    a_r4_no_underflow: assert property (@(posedge tick) disable iff (rst_act)
        (ce_act && !we_act && re_act && empty) |=> $stable(count));

    a_r4_no_overflow: assert property (@(posedge tick) disable iff (rst_act)
        count <= CW'(DEPTH));

    a_r5_first_word: assert property (@(posedge tick) disable iff (rst_act)
        (ce_act && we_act && empty) |=> dout == $past(din));

    a_r6_empty_count: assert property (@(posedge tick) disable iff (rst_act)
        empty == (count == '0));

    a_r6_full_count: assert property (@(posedge tick) disable iff (rst_act)
        full == (count == CW'(DEPTH)));

    a_r8_ce_hold: assert property (@(posedge tick) disable iff (rst_act)
        !ce_act |=> ($stable(count) && $stable(dout)));

endmodule

bind sr_fifo sr_fifo_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH), .CW(CW)) u_sr_fifo_chk (
    .tick(tick), .rst_act(rst_act), .ce_act(ce_act), .we_act(we_act),
    .re_act(re_act), .count(count), .din(din), .dout(dout),
    .empty(empty), .full(full)
);

// File: tb/test_sr_fifo.sv
module test_sr_fifo;

    localparam int PERIOD = 10;
    localparam int DEPTH  = 8;
    localparam int WIDTH  = 8;
    localparam int AEL    = 2;
    localparam int AFL    = 6;

    logic clk = 1'b0;
    logic rst = 1'b1, ce = 1'b1, we = 1'b0, re = 1'b0;
    logic [WIDTH-1:0] din = '0;

    logic [WIDTH-1:0] d0, d1;
    logic e0, f0, ae0, af0, e1, f1, ae1, af1;

    int checks = 0;
    int errors = 0;
    string cur_tag = "R5";
    logic [WIDTH-1:0] q0 [$];
    logic [WIDTH-1:0] q1 [$];

    always #(PERIOD/2) clk = ~clk;

    // primary: rising edge, active-high, asynchronous reset
    sr_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AE_LEVEL(AEL), .AF_LEVEL(AFL),
              .FALLING_EDGE(1'b0), .ACTIVE_LOW(1'b0), .ASYNC_RESET(1'b1)) i_sr_fifo (
        .clk(clk), .rst(rst), .clk_en(ce), .wr_en(we), .rd_en(re), .din(din),
        .dout(d0), .empty(e0), .full(f0), .almost_empty(ae0), .almost_full(af0)
    );

    // variant: falling edge, active-low controls, synchronous reset (R11 R12)
    sr_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AE_LEVEL(AEL), .AF_LEVEL(AFL),
              .FALLING_EDGE(1'b1), .ACTIVE_LOW(1'b1), .ASYNC_RESET(1'b0)) i_sr_fifo_alt (
        .clk(clk), .rst(~rst), .clk_en(~ce), .wr_en(~we), .rd_en(~re), .din(din),
        .dout(d1), .empty(e1), .full(f1), .almost_empty(ae1), .almost_full(af1)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic void model(ref logic [WIDTH-1:0] q [$], input bit sync_rst);
        if (rst && (!sync_rst || ce)) q.delete();
        else if (!rst && ce) begin
            if (we) begin
                if (q.size() < DEPTH) q.push_back(din);
            end else if (re && q.size() > 0) begin
                void'(q.pop_front());
            end
        end
    endfunction

    task automatic compare(input bit alt);
        int n;
        string pre;
        n   = alt ? q1.size() : q0.size();
        pre = alt ? "variant R11 R12" : "primary";
        chk("R6", {pre, " empty"}, alt ? e1 : e0, n == 0);
        chk("R6", {pre, " full"},  alt ? f1 : f0, n == DEPTH);
        chk("R7", {pre, " almost_empty"}, alt ? ae1 : ae0, n <= AEL);
        chk("R7", {pre, " almost_full"},  alt ? af1 : af0, n >= AFL);
        if (n > 0) chk(cur_tag, {pre, " dout"}, alt ? d1 : d0, alt ? q1[0] : q0[0]);
    endtask

    task automatic drive(input logic r, input logic c, input logic w, input logic rd,
                         input logic [WIDTH-1:0] d);
        rst = r; ce = c; we = w; re = rd; din = d;
    endtask

    task automatic finish_cycle();
        @(negedge clk); #1;
        model(q1, 1'b1);
        compare(1'b1);
        @(posedge clk); #1;
        model(q0, 1'b0);
        compare(1'b0);
    endtask

    task automatic step(input logic r, input logic c, input logic w, input logic rd,
                        input logic [WIDTH-1:0] d);
        drive(r, c, w, rd, d);
        finish_cycle();
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
    end

    initial begin
        @(posedge clk); #1;
        // reset state: R9 for the primary, R10 for the variant
        step(1, 1, 0, 0, 8'h00);
        step(1, 1, 0, 0, 8'h00);
        chk("R9", "reset empty", e0, 1'b1);
        chk("R10", "reset empty variant", e1, 1'b1);

        // R1 R5: fill to full with ordered words; first word visible at once
        cur_tag = "R1";
        step(0, 1, 1, 0, 8'hA0);
        chk("R5", "first word on dout", d0, 8'hA0);
        for (int i = 1; i < DEPTH; i++) step(0, 1, 1, 0, 8'hA0 + 8'(i));
        chk("R6", "full after fill", f0, 1'b1);

        // R4: write while full is dropped
        cur_tag = "R4";
        step(0, 1, 1, 0, 8'h55);
        step(0, 1, 1, 1, 8'h56);

        // R2: reads shift toward output
        cur_tag = "R2";
        for (int i = 0; i < 3; i++) step(0, 1, 0, 1, 8'h00);
        chk("R2", "dout after three reads", d0, 8'hA3);

        // R3: write and read together, only the write happens
        cur_tag = "R3";
        step(0, 1, 1, 1, 8'hC1);
        step(0, 1, 1, 1, 8'hC2);
        chk("R3", "dout unchanged by simultaneous read", d0, 8'hA3);

        // R8: clock enable low freezes everything
        cur_tag = "R8";
        step(0, 0, 1, 0, 8'hEE);
        step(0, 0, 0, 1, 8'h00);
        chk("R8", "dout held with enable low", d0, 8'hA3);

        // drain then R4 read while empty
        cur_tag = "R2";
        while (q0.size() > 0) step(0, 1, 0, 1, 8'h00);
        cur_tag = "R4";
        step(0, 1, 0, 1, 8'h00);
        chk("R4", "empty after read on empty", e0, 1'b1);

        // R5: mixed traffic against the queue model
        cur_tag = "R5";
        for (int i = 0; i < 400; i++)
            step(0, ($urandom % 8) != 0, ($urandom % 2) == 1, ($urandom % 2) == 1,
                 8'($urandom));

        // bring both to a known nonzero fill
        while (q0.size() > 0) step(0, 1, 0, 1, 8'h00);
        for (int i = 0; i < 4; i++) step(0, 1, 1, 0, 8'h30 + 8'(i));

        // R9: asynchronous clear, enable low, before any edge
        drive(1, 0, 0, 0, 8'h00);
        #1;
        chk("R9", "immediate clear", e0, 1'b1);
        cur_tag = "R10";
        finish_cycle();
        // R10: enable was low, so the variant still holds its words
        chk("R10", "sync reset ignored without enable", e1, 1'b0);
        step(1, 1, 0, 0, 8'h00);
        chk("R10", "sync reset with enable", e1, 1'b1);

        step(0, 1, 1, 0, 8'h77);
        chk("R11", "variant first word", d1, 8'h77);
        chk("R12", "variant not empty", e1, 1'b0);
        summary();
    end

endmodule